// File: doc/BRIEF.md
# Integer Line-Replicating Video Upscaler

This block takes a small source picture, one complete line at a time, and produces a full-size output raster. Each source pixel is repeated horizontally and each source line is repeated vertically. The repeat factor is the largest whole number that fits both output dimensions. The enlarged picture sits in the middle of the output window, and the rest of the window is black. Source lines arrive as a valid/ready pixel stream in the capture clock domain. The output raster (RGB, HSYNC, VSYNC, DE) runs in the output pixel clock domain and feeds a downstream serializer.

Only two source lines are ever stored. They sit in a pair of banks that the writer and the reader hand back and forth. Line ownership crosses the clock boundary as 2-bit Gray-coded line counts, and the frame-start marker crosses as a toggle. An output frame begins only after an input frame start has been seen. If the next source line is not complete when the reader needs it, the reader shows the current line again and pulses an underrun flag.

Back-pressure works as follows. A beat transfers on a rising `wr_clk` edge when `in_valid` and `in_ready` are both high. `in_ready` drops while both banks hold complete lines that have not yet been shown. The source may hold or change `in_valid` freely. The output side has no back-pressure.

Top module: `line_rep_upscaler`

## Requirements
- R1: The scale factor S is min(OUT_W/SRC_W, OUT_H/SRC_H), using integer division. Inside the image area, the output at column h and line v is source pixel (row (v-VB)/S, column (h-HB)/S) of the frame being shown.
- R2: The image is centred with HB=(OUT_W-S*SRC_W)/2 and VB=(OUT_H-S*SRC_H)/2. `out_rgb` is zero on the border and whenever `out_de` is low.
- R3: A running frame has lines of H_TOTAL cycles and V_TOTAL lines. `out_de` is high exactly for h<OUT_W and v<OUT_H. `out_hsync` is high for h in [OUT_W+H_FP, OUT_W+H_FP+H_SYNC). `out_vsync` is high for whole lines v in [OUT_H+V_FP, OUT_H+V_FP+V_SYNC). Both syncs are active high.
- R4: All outputs stay low until a beat with `in_sof` high has been accepted; a frame then starts at h=0, v=0. When a frame ends, the next frame starts on the following cycle if another frame start has been accepted; otherwise the outputs go low and wait.
- R5: SRC_W accepted beats make one line. A beat with `in_sof` high is column 0. `in_ready` goes low while two complete lines are stored and waiting to be shown.
- R6: A stored line returns to the writer only after the last of its S output lines. `in_ready` therefore cannot recover for a third line before that point.
- R7: At the end of the last output line of a source row other than the final row, if the next line is not complete, the current line is shown again. `underrun` is then high for one cycle, at the cycle of h=H_TOTAL-1 on that output line.
- R8: If no complete line is stored at the end of line VB-1, `underrun` pulses at h=H_TOTAL-1 of that line.
- R9: After reset, `out_de`, `out_hsync`, `out_vsync`, `out_rgb` and `underrun` are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Capture-side clock |
| wr_rst_n | input | 1 | Capture-side synchronous reset, active low |
| in_valid | input | 1 | Source pixel beat valid |
| in_ready | output | 1 | A line bank can take the beat |
| in_data | input | PIX_W | Source pixel, 24-bit RGB by default |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| out_clk | input | 1 | Output pixel clock |
| out_rst_n | input | 1 | Output-side synchronous reset, active low |
| out_rgb | output | PIX_W | Output pixel, zero outside the image |
| out_hsync | output | 1 | Horizontal sync, active high |
| out_vsync | output | 1 | Vertical sync, active high |
| out_de | output | 1 | Active-area data enable |
| underrun | output | 1 | One-cycle pulse: a needed line was not ready |

## Verification
Two functions can land on the same cycle: the end-of-row release that hands a bank back to the writer, and the underrun decision that keeps the current bank. The bench provokes this by withholding the last row of one frame, so the release point of the middle row meets an incomplete next line. It then withholds a whole frame apart from its first beat, so the start-of-image check and every row release fail in turn. For each of these cycles the bench judges the `underrun` timing and which source row is repeated. It also checks that the following frame is still read in order.

// File: rtl/upscl_pkg.sv
`timescale 1ns/1ps
package upscl_pkg;
  // Largest whole-number factor that fits both dimensions
  function automatic int fit_scale(input int sw, input int sh, input int ow, input int oh);
    int a;
    int b;
    a = ow / sw;
    b = oh / sh;
    return (a < b) ? a : b;
  endfunction

  function automatic logic [1:0] bin2gray(input logic [1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [1:0] gray2bin(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction
endpackage

// File: rtl/upscl_sync.sv
`timescale 1ns/1ps
module upscl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/upscl_writer.sv
`timescale 1ns/1ps
module upscl_writer #(
  parameter int SRC_W = 480,
  parameter int PIX_W = 24,
  localparam int CW   = $clog2(SRC_W),
  localparam int AW   = $clog2(2*SRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic [1:0]       rgray_sync,
  output logic [1:0]       wgray,
  output logic [1:0]       occ,
  output logic             fs_tgl,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [PIX_W-1:0] wdata
);
  import upscl_pkg::*;

  localparam logic [CW-1:0] COL_LAST = CW'(SRC_W-1);

  logic [CW-1:0] wcol, col_eff;
  logic [1:0]    wptr;

  assign occ      = wptr - gray2bin(rgray_sync);
  assign in_ready = (occ != 2'd2);
  assign we       = in_valid && in_ready;
  assign col_eff  = in_sof ? '0 : wcol;
  assign waddr    = (wptr[0] ? AW'(SRC_W) : '0) + AW'(col_eff);
  assign wdata    = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcol   <= '0;
      wptr   <= '0;
      wgray  <= '0;
      fs_tgl <= 1'b0;
    end else if (we) begin
      if (in_sof) fs_tgl <= ~fs_tgl;
      if (col_eff == COL_LAST) begin
        wcol  <= '0;
        wptr  <= wptr + 2'd1;
        wgray <= bin2gray(wptr + 2'd1);
      end else begin
        wcol <= col_eff + 1'b1;
      end
    end
  end
endmodule

// File: rtl/upscl_linemem.sv
`timescale 1ns/1ps
module upscl_linemem #(
  parameter int DEPTH = 960,
  parameter int PIX_W = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             rclk,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/upscl_raster.sv
`timescale 1ns/1ps
module upscl_raster #(
  parameter int H_TOTAL = 2200,
  parameter int V_TOTAL = 1125,
  localparam int HW     = $clog2(H_TOTAL+1),
  localparam int VW     = $clog2(V_TOTAL+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [HW-1:0] h,
  output logic [VW-1:0] v,
  output logic          running,
  output logic          line_end,
  output logic          frame_end
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL-1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL-1);

  assign line_end  = running && (h == H_LAST);
  assign frame_end = line_end && (v == V_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h       <= '0;
      v       <= '0;
      running <= 1'b0;
    end else if (!running) begin
      h       <= '0;
      v       <= '0;
      running <= start;
    end else if (line_end) begin
      h <= '0;
      if (v == V_LAST) begin
        v       <= '0;
        running <= start;
      end else begin
        v <= v + 1'b1;
      end
    end else begin
      h <= h + 1'b1;
    end
  end
endmodule

// File: rtl/line_rep_upscaler.sv
`timescale 1ns/1ps
module line_rep_upscaler #(
  parameter int SRC_W   = 480,
  parameter int SRC_H   = 272,
  parameter int OUT_W   = 1920,
  parameter int OUT_H   = 1080,
  parameter int H_TOTAL = 2200,
  parameter int H_FP    = 88,
  parameter int H_SYNC  = 44,
  parameter int V_TOTAL = 1125,
  parameter int V_FP    = 4,
  parameter int V_SYNC  = 5,
  parameter int PIX_W   = 24
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             out_clk,
  input  logic             out_rst_n,
  output logic [PIX_W-1:0] out_rgb,
  output logic             out_hsync,
  output logic             out_vsync,
  output logic             out_de,
  output logic             underrun
);
  import upscl_pkg::*;

  localparam int SCALE = fit_scale(SRC_W, SRC_H, OUT_W, OUT_H);
  localparam int HB    = (OUT_W - SRC_W*SCALE) / 2;
  localparam int VB    = (OUT_H - SRC_H*SCALE) / 2;
  localparam int HW    = $clog2(H_TOTAL+1);
  localparam int VW    = $clog2(V_TOTAL+1);
  localparam int AW    = $clog2(2*SRC_W);
  localparam int RCW   = $clog2(SRC_W+1);
  localparam int RW    = $clog2(SRC_H+1);
  localparam int SCW   = $clog2(SCALE+1);

  localparam logic [HW-1:0]  H_IMG0  = HW'(HB);
  localparam logic [HW-1:0]  H_IMG1  = HW'(HB + SRC_W*SCALE);
  localparam logic [HW-1:0]  H_ACT   = HW'(OUT_W);
  localparam logic [HW-1:0]  H_SYN0  = HW'(OUT_W + H_FP);
  localparam logic [HW-1:0]  H_SYN1  = HW'(OUT_W + H_FP + H_SYNC);
  localparam logic [VW-1:0]  V_IMG0  = VW'(VB);
  localparam logic [VW-1:0]  V_IMG1  = VW'(VB + SRC_H*SCALE);
  localparam logic [VW-1:0]  V_PRE   = VW'(VB - 1);
  localparam logic [VW-1:0]  V_ACT   = VW'(OUT_H);
  localparam logic [VW-1:0]  V_SYN0  = VW'(OUT_H + V_FP);
  localparam logic [VW-1:0]  V_SYN1  = VW'(OUT_H + V_FP + V_SYNC);
  localparam logic [SCW-1:0] S_LAST  = SCW'(SCALE-1);
  localparam logic [RW-1:0]  ROW_LAST = RW'(SRC_H-1);

  // capture domain
  logic [1:0]       wgray, rgray_w, wr_occ;
  logic             fs_tgl, mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [PIX_W-1:0] mem_wdata;

  upscl_writer #(.SRC_W(SRC_W), .PIX_W(PIX_W)) u_writer (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .rgray_sync(rgray_w), .wgray(wgray),
    .occ(wr_occ), .fs_tgl(fs_tgl), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  // output domain
  logic [1:0]       rgray, wgray_r, rptr, avail;
  logic             fs_r, fs_prev, fs_edge, pending, take;
  logic [HW-1:0]    h;
  logic [VW-1:0]    v;
  logic             running, line_end, frame_end;
  logic             row_img, col_img, last_row, pop_ok, pix_en;
  logic [SCW-1:0]   prep, lrep;
  logic [RCW-1:0]   rcol;
  logic [RW-1:0]    srow;
  logic [AW-1:0]    mem_raddr;
  logic [PIX_W-1:0] mem_q;

  upscl_sync #(.W(2)) u_sync_rp (.clk(wr_clk),  .rst_n(wr_rst_n),  .d(rgray),  .q(rgray_w));
  upscl_sync #(.W(2)) u_sync_wp (.clk(out_clk), .rst_n(out_rst_n), .d(wgray),  .q(wgray_r));
  upscl_sync #(.W(1)) u_sync_fs (.clk(out_clk), .rst_n(out_rst_n), .d(fs_tgl), .q(fs_r));

  upscl_linemem #(.DEPTH(2*SRC_W), .PIX_W(PIX_W)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rclk(out_clk), .raddr(mem_raddr), .rdata(mem_q)
  );

  upscl_raster #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_raster (
    .clk(out_clk), .rst_n(out_rst_n), .start(pending), .h(h), .v(v),
    .running(running), .line_end(line_end), .frame_end(frame_end)
  );

  assign fs_edge   = fs_r ^ fs_prev;
  assign take      = pending && (!running || frame_end);
  assign avail     = gray2bin(wgray_r) - rptr;
  assign row_img   = (v >= V_IMG0) && (v < V_IMG1);
  assign col_img   = (h >= H_IMG0) && (h < H_IMG1);
  assign last_row  = (srow == ROW_LAST);
  assign pop_ok    = last_row ? (avail != 2'd0) : (avail >= 2'd2);
  assign mem_raddr = (rptr[0] ? AW'(SRC_W) : '0) + AW'(rcol);

  always_ff @(posedge out_clk) begin
    if (!out_rst_n) begin
      fs_prev  <= 1'b0;
      pending  <= 1'b0;
      prep     <= '0;
      rcol     <= '0;
      lrep     <= '0;
      srow     <= '0;
      rptr     <= '0;
      rgray    <= '0;
      underrun <= 1'b0;
    end else begin
      fs_prev  <= fs_r;
      pending  <= fs_edge | (pending & ~take);
      rgray    <= bin2gray(rptr);
      underrun <= 1'b0;
      // horizontal replication
      if (!running || line_end) begin
        prep <= '0;
        rcol <= '0;
      end else if (row_img && col_img) begin
        if (prep == S_LAST) begin
          prep <= '0;
          rcol <= rcol + 1'b1;
        end else begin
          prep <= prep + 1'b1;
        end
      end
      // vertical replication and bank release
      if (!running || frame_end) begin
        lrep <= '0;
        srow <= '0;
      end else if (line_end && row_img) begin
        if (lrep == S_LAST) begin
          lrep <= '0;
          srow <= srow + 1'b1;
          if (pop_ok)         rptr     <= rptr + 2'd1;
          else if (!last_row) underrun <= 1'b1;
        end else begin
          lrep <= lrep + 1'b1;
        end
      end
      if (line_end && (v == V_PRE) && (avail == 2'd0)) underrun <= 1'b1;
    end
  end

  // output stage aligned with the one-cycle memory read
  always_ff @(posedge out_clk) begin
    if (!out_rst_n) begin
      out_de    <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      pix_en    <= 1'b0;
    end else begin
      out_de    <= running && (h < H_ACT) && (v < V_ACT);
      out_hsync <= running && (h >= H_SYN0) && (h < H_SYN1);
      out_vsync <= running && (v >= V_SYN0) && (v < V_SYN1);
      pix_en    <= running && row_img && col_img;
    end
  end

  assign out_rgb = pix_en ? mem_q : '0;
endmodule

// File: rtl/upscl_checker.sv
`timescale 1ns/1ps
module upscl_checker #(
  parameter int PIX_W = 24
) (
  input logic             out_clk,
  input logic             out_rst_n,
  input logic             wr_clk,
  input logic             wr_rst_n,
  input logic [1:0]       wr_occ,
  input logic             out_de,
  input logic             out_hsync,
  input logic             out_vsync,
  input logic [PIX_W-1:0] out_rgb,
  input logic             underrun
);
  AST_SYNC_OUTSIDE_DE: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    out_de |-> (!out_hsync && !out_vsync)); // R3

  AST_BLACK_OUTSIDE_DE: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    !out_de |-> (out_rgb == '0)); // R2

  AST_UNDERRUN_ONE_CYCLE: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    underrun |=> !underrun); // R7

  AST_UNDERRUN_IN_BLANK: assert property (@(posedge out_clk) disable iff (!out_rst_n)
    underrun |-> !out_de); // R8

  AST_NO_OVERFILL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_occ <= 2'd2); // R5
endmodule

bind line_rep_upscaler upscl_checker #(.PIX_W(PIX_W)) u_chk (
  .out_clk(out_clk), .out_rst_n(out_rst_n), .wr_clk(wr_clk), .wr_rst_n(wr_rst_n),
  .wr_occ(wr_occ), .out_de(out_de), .out_hsync(out_hsync), .out_vsync(out_vsync),
  .out_rgb(out_rgb), .underrun(underrun)
);

// File: tb/line_rep_upscaler_test.sv
`timescale 1ns/1ps
module line_rep_upscaler_test;
  localparam int SW = 4, SH = 3, OW = 14, OH = 11;
  localparam int HT = 18, HFP = 1, HS = 2, VT = 13, VFP = 1, VS = 1;
  localparam int S  = 3;                  // min(14/4, 11/3)
  localparam int HB = (OW - S*SW) / 2;    // 1
  localparam int VB = (OH - S*SH) / 2;    // 1
  localparam int NFR = 5;

  logic wr_clk = 1'b0, out_clk = 1'b0;
  logic wr_rst_n = 1'b0, out_rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [23:0] in_data = '0;
  logic in_ready, out_hsync, out_vsync, out_de, underrun;
  logic [23:0] out_rgb;

  always #3.5 wr_clk  = ~wr_clk;
  always #2.5 out_clk = ~out_clk;   // 200 MHz

  line_rep_upscaler #(
    .SRC_W(SW), .SRC_H(SH), .OUT_W(OW), .OUT_H(OH), .H_TOTAL(HT), .H_FP(HFP),
    .H_SYNC(HS), .V_TOTAL(VT), .V_FP(VFP), .V_SYNC(VS), .PIX_W(24)
  ) uut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_clk(out_clk), .out_rst_n(out_rst_n),
    .out_rgb(out_rgb), .out_hsync(out_hsync), .out_vsync(out_vsync), .out_de(out_de),
    .underrun(underrun)
  );

  int checks = 0, failures = 0;
  int out_cyc = 0, pop_cyc = -1, acc_cyc = -1;
  int mh = 0, mv = 0, fk = 0;
  bit in_frame = 0, stalled = 0, mon_on = 0;

  function automatic logic [23:0] pix(input int k, input int r, input int c);
    return {8'(k+1), 8'(r+1), 8'(c+1)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s frame=%0d h=%0d v=%0d actual=%0h expected=%0h", tag, fk, mh, mv, act, exp);
    end
  endtask

  // output monitor with an arithmetic raster model
  always @(negedge out_clk) begin
    if (mon_on) begin
      out_cyc++;
      if (!in_frame && out_de) begin
        in_frame = 1;
        mh = 0;
        mv = 0;
      end
      if (in_frame) begin
        bit img, e_ur;
        int r, c;
        logic [23:0] e_rgb;
        img = (mh >= HB) && (mh < HB + S*SW) && (mv >= VB) && (mv < VB + S*SH);
        e_rgb = '0;
        if (img) begin
          r = (mv - VB) / S;
          c = (mh - HB) / S;
          if (fk == 3 && r == 2) r = 1;   // R7: row 1 repeated
          e_rgb = pix(fk, r, c);
        end
        e_ur = (mh == HT-1) &&
               ((fk == 3 && mv == VB + 2*S - 1) ||
                (fk == 4 && (mv == VB - 1 || mv == VB + S - 1 || mv == VB + 2*S - 1)));
        chk("R3 de", 32'(out_de), 32'((mh < OW) && (mv < OH)));
        chk("R3 hsync", 32'(out_hsync), 32'((mh >= OW+HFP) && (mh < OW+HFP+HS)));
        chk("R3 vsync", 32'(out_vsync), 32'((mv >= OH+VFP) && (mv < OH+VFP+VS)));
        if (fk < 4 || !img) chk(img ? "R1 pixel" : "R2 border", 32'(out_rgb), 32'(e_rgb));
        if (fk == 3 || fk == 4) chk(fk == 3 ? "R7 underrun" : "R8 underrun", 32'(underrun), 32'(e_ur));
        else chk("R7 no underrun", 32'(underrun), 32'(e_ur));
        if (fk == 0 && mh == HT-1 && mv == VB + S - 1) pop_cyc = out_cyc;
        mh++;
        if (mh == HT) begin
          mh = 0;
          mv++;
          if (mv == VT) begin
            in_frame = 0;
            fk++;
          end
        end
      end else begin
        chk("R4 idle", {out_hsync, out_vsync, underrun, out_rgb}, '0);
      end
    end
  end

  task automatic send(input logic [23:0] d, input logic sof, output bit saw_stall);
    @(negedge wr_clk);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = sof;
    saw_stall = 0;
    while (!in_ready) begin
      saw_stall = 1;
      @(negedge wr_clk);
    end
    @(posedge wr_clk);
  endtask

  // source stream: frames 0..2 whole, frame 3 missing its last row, frame 4 one beat
  initial begin
    bit st;
    wait (wr_rst_n);
    repeat (40) @(negedge wr_clk);
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < ((k == 3) ? SH - 1 : SH); r++) begin
        for (int c = 0; c < SW; c++) begin
          send(pix(k, r, c), (r == 0 && c == 0), st);
          if (k == 0 && r == 2 && c == 0) begin
            stalled = st;
            acc_cyc = out_cyc;
          end
        end
      end
    end
    send(pix(4, 0, 0), 1'b1, st);
    @(negedge wr_clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  end

  initial begin
    repeat (6) @(negedge out_clk);
    wr_rst_n  = 1'b1;
    out_rst_n = 1'b1;
    @(negedge out_clk);
    @(negedge out_clk);
    // R9 reset state
    chk("R9 in_ready", 32'(in_ready), 32'd1);
    chk("R9 outputs", {out_de, out_hsync, out_vsync, underrun, out_rgb}, '0);
    mon_on = 1;
    for (int i = 0; i < 200000 && fk < NFR; i++) @(negedge out_clk);
    if (fk < NFR) begin
      failures++;
      checks++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d frames", fk, NFR);
    end else begin
      repeat (300) @(negedge out_clk);
      chk("R4 frame count", 32'(fk), 32'(NFR));
      chk("R5 ready low with two lines held", 32'(stalled), 32'd1);
      chk("R6 third line after release", 32'(acc_cyc > pop_cyc && pop_cyc > 0), 32'd1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule